// File: doc/BRIEF.md
# Logic Self-Test Sequencer with Pattern Generator and Response Compactor

This block runs a self-test of scan-inserted logic without an external tester. A 32-bit linear feedback shift register produces pseudo-random stimulus. Its low-order bits drive one scan-in line per chain while scan enable is high. After each pattern is fully loaded, the block drops scan enable for exactly one clock so that the logic under test captures its response. The captured responses then leave the chains while the next pattern is loaded, and a 32-bit multiple-input signature register folds them into one signature.

A test is started with a seed, a pattern count and the expected signature. When the last response has been unloaded, the block compares the signature with the expected value and raises done together with a pass flag. The signature stays on its own output port until the next test starts. The logic under test, the storage of the expected value and its precomputation all sit outside this block.

Top module: `lbist_ctrl`

## Requirements
- R1: While reset is high and after it is released, scan_en, done and pass are 0 and signature is 0.
- R2: The generator steps once per shift clock with the Galois rule next = {s[30:0],0} XOR (s[31] ? 32'h0040_0007 : 0), which is the polynomial x^32+x^22+x^2+x+1. scan_in[c] carries generator bit c. A start loads the seed into the generator, and a seed of zero is replaced by 32'h0000_0001, so in the first shift cycle scan_in equals the low bits of the effective seed.
- R3: Each pattern is shifted for CHAIN_LEN clocks with scan_en high, followed by exactly one clock with scan_en low. After the last pattern, one more unload of CHAIN_LEN clocks with scan_en high follows, then a single compare clock with scan_en low.
- R4: A start clears the signature register to 0. On every clock with scan_en high, except during the first load of a test, the register becomes {m[30:0],0} XOR (m[31] ? 32'h0040_0007 : 0) XOR the zero-extended scan_out bus (chain c into bit c). It does not change on capture or compare clocks.
- R5: When done rises, pass is 1 exactly when signature equals golden.
- R6: done, pass and signature hold their values from the end of a test until the next accepted start, which clears done and pass.
- R7: A start pulse while a test is running is ignored and does not alter the running test's signature or timing.
- R8: Counting the clock edge that samples start as edge 0, done first reads 1 after edge N*(CHAIN_LEN+1)+CHAIN_LEN+1 for N patterns. With N = 0 the block does no shifting and raises done after edge 1, with a signature of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test; sampled only when idle |
| seed | input | 32 | Generator seed, zero replaced by 1 |
| num_patterns | input | PAT_W | Number of patterns to apply |
| golden | input | 32 | Expected signature |
| scan_en | output | 1 | 1 = shift, 0 = capture or idle |
| scan_in | output | NCHAINS | Serial stimulus, one bit per chain |
| scan_out | input | NCHAINS | Serial response, one bit per chain |
| done | output | 1 | Test finished; held until next start |
| pass | output | 1 | Signature matched golden |
| signature | output | 32 | Compacted response |

## Verification
The pass check assumes that golden is held steady for the whole test, and the signature-hold check assumes that start only matters when the block is idle. The stimulus sets seed, count and golden before each start and leaves them unchanged until done. Start pulses during a test are issued only in the one deliberate case that checks they are ignored. The bench models the scan chains with a fixed capture function, so every scan_out bit is defined once the first pattern has been loaded. That matches the block's rule of discarding the first unload. Pattern counts are kept small enough that each test takes a few hundred clocks.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  localparam int          SIG_W         = 32;
  localparam logic [31:0] FB_POLY       = 32'h0040_0007;
  localparam logic [31:0] SEED_FALLBACK = 32'h0000_0001;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SHIFT,
    PH_CAPTURE,
    PH_COMPARE
  } phase_t;

  // One Galois step of the shared feedback polynomial
  function automatic logic [SIG_W-1:0] galois_step(input logic [SIG_W-1:0] s);
    return {s[SIG_W-2:0], 1'b0} ^ (s[SIG_W-1] ? FB_POLY : '0);
  endfunction
endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg
  import lbist_pkg::*;
#(
  parameter int NCHAINS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [SIG_W-1:0]   seed,
  input  logic               advance,
  output logic [NCHAINS-1:0] taps
);
  logic [SIG_W-1:0] lfsr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q <= SEED_FALLBACK;
    end else if (load) begin
      lfsr_q <= (seed == '0) ? SEED_FALLBACK : seed;
    end else if (advance) begin
      lfsr_q <= galois_step(lfsr_q);
    end
  end

  assign taps = lfsr_q[NCHAINS-1:0];
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr
  import lbist_pkg::*;
#(
  parameter int NCHAINS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               absorb,
  input  logic [NCHAINS-1:0] din,
  output logic [SIG_W-1:0]   sig
);
  logic [SIG_W-1:0] din_ext;
  logic [SIG_W-1:0] sig_q;

  for (genvar b = 0; b < SIG_W; b++) begin : g_ext
    if (b < NCHAINS) begin : g_bit
      assign din_ext[b] = din[b];
    end else begin : g_pad
      assign din_ext[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sig_q <= '0;
    end else if (absorb) begin
      sig_q <= galois_step(sig_q) ^ din_ext;
    end
  end

  assign sig = sig_q;
endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
  import lbist_pkg::*;
#(
  parameter int CHAIN_LEN = 16,
  parameter int PAT_W     = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PAT_W-1:0] num_patterns,
  output phase_t           phase,
  output logic             scan_en,
  output logic             accept,
  output logic             prpg_adv,
  output logic             misr_abs,
  output logic             cmp_now
);
  localparam int BC_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(CHAIN_LEN - 1);

  phase_t           phase_q;
  logic [BC_W-1:0]  bitcnt_q;
  logic [PAT_W-1:0] patcnt_q;
  logic [PAT_W-1:0] target_q;
  logic             captured_q;
  logic             sen_q;

  assign accept   = start && (phase_q == PH_IDLE);
  assign prpg_adv = (phase_q == PH_SHIFT);
  assign misr_abs = (phase_q == PH_SHIFT) && captured_q;
  assign cmp_now  = (phase_q == PH_COMPARE);
  assign phase    = phase_q;
  assign scan_en  = sen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      bitcnt_q   <= '0;
      patcnt_q   <= '0;
      target_q   <= '0;
      captured_q <= 1'b0;
      sen_q      <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            target_q   <= num_patterns;
            bitcnt_q   <= '0;
            patcnt_q   <= '0;
            captured_q <= 1'b0;
            if (num_patterns == '0) begin
              phase_q <= PH_COMPARE;
              sen_q   <= 1'b0;
            end else begin
              phase_q <= PH_SHIFT;
              sen_q   <= 1'b1;
            end
          end
        end
        PH_SHIFT: begin
          if (bitcnt_q == LAST_BIT) begin
            bitcnt_q <= '0;
            sen_q    <= 1'b0;
            phase_q  <= (patcnt_q == target_q) ? PH_COMPARE : PH_CAPTURE;
          end else begin
            bitcnt_q <= bitcnt_q + 1'b1;
          end
        end
        PH_CAPTURE: begin
          patcnt_q   <= patcnt_q + 1'b1;
          captured_q <= 1'b1;
          sen_q      <= 1'b1;
          phase_q    <= PH_SHIFT;
        end
        PH_COMPARE: begin
          phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
#(
  parameter int NCHAINS   = 4,
  parameter int CHAIN_LEN = 16,
  parameter int PAT_W     = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [31:0]        seed,
  input  logic [PAT_W-1:0]   num_patterns,
  input  logic [31:0]        golden,
  output logic               scan_en,
  output logic [NCHAINS-1:0] scan_in,
  input  logic [NCHAINS-1:0] scan_out,
  output logic               done,
  output logic               pass,
  output logic [31:0]        signature
);
  phase_t phase;
  logic   accept;
  logic   prpg_adv;
  logic   misr_abs;
  logic   cmp_now;
  logic   done_q;
  logic   pass_q;

  lbist_seq #(
    .CHAIN_LEN(CHAIN_LEN),
    .PAT_W    (PAT_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .num_patterns(num_patterns),
    .phase       (phase),
    .scan_en     (scan_en),
    .accept      (accept),
    .prpg_adv    (prpg_adv),
    .misr_abs    (misr_abs),
    .cmp_now     (cmp_now)
  );

  lbist_prpg #(.NCHAINS(NCHAINS)) u_prpg (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .seed   (seed),
    .advance(prpg_adv),
    .taps   (scan_in)
  );

  lbist_misr #(.NCHAINS(NCHAINS)) u_misr (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .absorb(misr_abs),
    .din   (scan_out),
    .sig   (signature)
  );

  always_ff @(posedge clk) begin
    if (rst || accept) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else if (cmp_now) begin
      done_q <= 1'b1;
      pass_q <= (signature == golden);
    end
  end

  assign done = done_q;
  assign pass = pass_q;
endmodule

// File: rtl/lbist_ctrl_chk.sv
module lbist_ctrl_chk
  import lbist_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [31:0] golden,
  input logic        scan_en,
  input logic        done,
  input logic        pass,
  input logic [31:0] signature,
  input phase_t      phase
);
  AST_CAPTURE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CAPTURE) |=> (scan_en && phase == PH_SHIFT)); // R3

  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    done |-> !scan_en); // R3

  AST_START_CLEARS_SIG: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && start) |=> (signature == '0 && !done)); // R4

  AST_PASS_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (pass == (signature == golden))); // R5

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(signature) && $stable(pass))); // R6

  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |-> !done); // R7
endmodule

bind lbist_ctrl lbist_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .golden   (golden),
  .scan_en  (scan_en),
  .done     (done),
  .pass     (pass),
  .signature(signature),
  .phase    (phase)
);

// File: tb/lbist_ctrl_bench.sv
module lbist_ctrl_bench;
  localparam int NCH   = 4;
  localparam int L     = 16;
  localparam int PW    = 12;
  localparam logic [31:0] POLY = 32'h0040_0007;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [31:0]   seed = '0;
  logic [PW-1:0] num_patterns = '0;
  logic [31:0]   golden = '0;
  logic          scan_en;
  logic [NCH-1:0] scan_in;
  logic [NCH-1:0] scan_out;
  logic          done;
  logic          pass;
  logic [31:0]   signature;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  logic [NCH-1:0][L-1:0] chains = '0;

  always #5 clk = ~clk;

  lbist_ctrl #(.NCHAINS(NCH), .CHAIN_LEN(L), .PAT_W(PW)) u_lbist_ctrl (
    .clk(clk), .rst(rst), .start(start), .seed(seed),
    .num_patterns(num_patterns), .golden(golden), .scan_en(scan_en),
    .scan_in(scan_in), .scan_out(scan_out), .done(done), .pass(pass),
    .signature(signature)
  );

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], 1'b0} ^ (s[31] ? POLY : 32'h0);
  endfunction

  function automatic logic [NCH-1:0][L-1:0] cap_fn(input logic [NCH-1:0][L-1:0] x);
    logic [NCH-1:0][L-1:0] r;
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < L; i++)
        r[c][i] = x[c][i] ^ x[(c+1)%NCH][(i+3)%L] ^ ((i % 2) == 1);
    return r;
  endfunction

  // Logic-under-test model: shift when scan_en, capture otherwise
  always @(posedge clk) begin
    if (scan_en) begin
      for (int c = 0; c < NCH; c++) chains[c] <= {chains[c][L-2:0], scan_in[c]};
    end else begin
      chains <= cap_fn(chains);
    end
  end
  for (genvar c = 0; c < NCH; c++) begin : g_tail
    assign scan_out[c] = chains[c][L-1];
  end

  function automatic logic [31:0] tails(input logic [NCH-1:0][L-1:0] x);
    logic [31:0] t = '0;
    for (int c = 0; c < NCH; c++) t[c] = x[c][L-1];
    return t;
  endfunction

  function automatic logic [31:0] ref_sig(input logic [31:0] sd, input int n);
    logic [31:0] p = (sd == 0) ? 32'h1 : sd;
    logic [31:0] m = '0;
    logic [NCH-1:0][L-1:0] ch = '0;
    bit have = 0;
    for (int k = 0; k < n; k++) begin
      for (int b = 0; b < L; b++) begin
        if (have) m = step(m) ^ tails(ch);
        for (int c = 0; c < NCH; c++) ch[c] = {ch[c][L-2:0], p[c]};
        p = step(p);
      end
      ch = cap_fn(ch);
      have = 1;
    end
    if (n > 0) begin
      for (int b = 0; b < L; b++) begin
        m = step(m) ^ tails(ch);
        for (int c = 0; c < NCH; c++) ch[c] = {ch[c][L-2:0], p[c]};
        p = step(p);
      end
    end
    return m;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  // mode: 0 golden=expected, 1 golden=expected^1, 2 also poke start mid-run
  task automatic run_test(input logic [31:0] sd, input int n, input int mode);
    logic [31:0] exp_sig = ref_sig(sd, n);
    logic [31:0] eff = (sd == 0) ? 32'h1 : sd;
    int cnt = 0;
    int run = 0;
    int bad_run = 0;
    int lows = 0;
    int exp_cnt = (n == 0) ? 1 : n * (L + 1) + L + 1;
    @(negedge clk);
    seed = sd;
    num_patterns = PW'(n);
    golden = (mode == 1) ? (exp_sig ^ 32'h1) : exp_sig;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n > 0) chk("R2 first scan_in", 32'(scan_in), 32'(eff[NCH-1:0]));
    chk("R4 cleared at start", signature, 32'h0);
    while (!done && cnt < 5000) begin
      if (scan_en) run++;
      else if (cnt > 0 || n == 0) begin
        if (run != L && n > 0) bad_run++;
        run = 0;
        lows++;
      end
      if (mode == 2 && cnt == 7) start = 1'b1;
      if (mode == 2 && cnt == 8) start = 1'b0;
      if (mode == 2 && cnt == 7) begin
        seed = 32'hDEAD_BEEF;
        num_patterns = PW'(1);
      end
      @(negedge clk);
      cnt++;
    end
    chk("R8 done cycle", 32'(cnt), 32'(exp_cnt));
    chk("R3 shift/capture runs", 32'(bad_run), 32'h0);
    chk("R3 low clocks", 32'(lows), (n == 0) ? 32'(1) : 32'(n + 1));
    chk(mode == 2 ? "R7 signature after ignored start" : "R4 signature",
        signature, exp_sig);
    chk("R5 pass", 32'(pass), (mode == 1) ? 32'h0 : 32'h1);
    repeat (6) @(negedge clk);
    chk("R6 done held", 32'(done), 32'h1);
    chk("R6 signature held", signature, exp_sig);
    chk("R6 pass held", 32'(pass), (mode == 1) ? 32'h0 : 32'h1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 scan_en in reset", 32'(scan_en), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 scan_en", 32'(scan_en), 32'h0);
    chk("R1 done", 32'(done), 32'h0);
    chk("R1 pass", 32'(pass), 32'h0);
    chk("R1 signature", signature, 32'h0);

    // R2: zero seed behaves as seed 1
    run_test(32'h0, 3, 0);
    run_test(32'h1, 3, 0);
    chk("R2 zero seed equals seed one", ref_sig(32'h0, 3), ref_sig(32'h1, 3));
    // R8: empty test, R5 mismatch, R7 ignored start
    run_test(32'h1234_5678, 0, 0);
    run_test(32'hCAFE_0001, 1, 1);
    run_test(32'h8000_0000, 4, 2);
    for (int t = 0; t < 8; t++) begin
      logic [31:0] sd = $urandom();
      int n = 1 + int'($urandom_range(0, 19));
      run_test(sd, n, int'($urandom_range(0, 1)));
    end
    finish_run();
  end
endmodule